// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address for one port of a synchronous memory. It keeps three registers of `ADDR_W` bits: a counter that addresses the array, a mask that limits which counter bits may move, and a mirror that remembers the last address loaded. Each clock edge applies one operation, chosen from four control inputs. The counter operations are clear, load, readback, step and hold. The mask operations are set-all-ones, load and readback.

The mask splits the counter into two regions. Bits where the mask is 0 are frozen. Bits where the mask is 1 form the region that counts. When a step is requested while every counting bit is already 1, the counter does not wrap to zero. It reloads the address held in the mirror instead, so the same burst can be replayed without reloading it from outside. An interrupt flag marks that cycle.

An active-low reset clears the registers at once, whatever the other inputs are. The reset is released in step with the clock.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, the counter and the mirror read all zeros and the mask reads all ones, regardless of the other inputs. Operations resume two clock edges after `rst_n` rises.
- R2: The operation is decoded from `sel_counter`, then `zero_n`, then `strobe_n`, then `step_n`, as follows:
  - With `sel_counter`=1: `zero_n`=0 clears; `strobe_n`=0 with `step_n`=0 loads; `strobe_n`=0 with `step_n`=1 reads back; `strobe_n`=1 with `step_n`=0 steps; `strobe_n`=1 with `step_n`=1 holds.
  - With `sel_counter`=0: `zero_n`=0 sets the mask; `strobe_n`=0 with `step_n`=0 loads the mask; `strobe_n`=0 with `step_n`=1 reads back the mask; `strobe_n`=1 is reserved.
  - Mask operations never change `mem_addr`.
- R3: A counter load writes `addr_in` into both the counter and the mirror.
- R4: A counter clear zeroes the counter and mirror bits where the mask is 1, and keeps the bits where the mask is 0.
- R5: A step adds one at the lowest bit position where the mask is 1, and keeps every bit where the mask is 0. With bit 0 masked the counter advances by two. With an all-zero mask a step changes nothing.
- R6: A step taken while every counter bit under a 1 in a nonzero mask is 1 loads the counter from the mirror. `wrap_irq` is high during exactly such a step cycle, and is low otherwise.
- R7: Mask set makes the mask all ones. Mask load writes `addr_in` into the mask unchanged. Neither operation touches the counter or the mirror.
- R8: `rdbk_oe` is high only in a counter-readback or mask-readback cycle. `rdbk_data` then carries the counter or the mask register value, and is zero otherwise.
- R9: A reserved operation changes no register and does not enable the readback output.
- R10: A hold leaves the counter and the mirror unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low master reset |
| sel_counter | input | 1 | 1 selects counter operations, 0 selects mask operations |
| zero_n | input | 1 | Active-low clear (counter) or set (mask) |
| strobe_n | input | 1 | Active-low address strobe |
| step_n | input | 1 | Active-low count enable |
| addr_in | input | ADDR_W | Address or mask value to load |
| mem_addr | output | ADDR_W | Current counter value to the memory array |
| rdbk_data | output | ADDR_W | Readback value |
| rdbk_oe | output | 1 | Readback output enable |
| wrap_irq | output | 1 | High in a step cycle that reloads from the mirror |

## Verification
The hardest case to reach from the ports is a wrap-around reload in which the mirror and the counter differ in the frozen upper bits. It is also hard to observe the mirror after a reset or after a clear, because no port shows the mirror. The stimulus narrows the mask before stepping, so a wrap comes within a few cycles. After each wrap, `mem_addr` shows exactly what the mirror held. Random phases load only contiguous masks, some with bit 0 cleared. They also mix loads, clears and mask changes in the middle of a burst, so that masked bits and the mirror drift apart from the counter.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [3:0] {
    OP_CNT_CLR,
    OP_CNT_LOAD,
    OP_CNT_RDBK,
    OP_CNT_STEP,
    OP_CNT_HOLD,
    OP_MSK_SET,
    OP_MSK_LOAD,
    OP_MSK_RDBK,
    OP_RSVD
  } bac_op_e;

  function automatic bac_op_e bac_decode(input logic sel, input logic zero_n,
                                         input logic strobe_n, input logic step_n);
    bac_op_e op;
    if (sel) begin
      if (!zero_n)                  op = OP_CNT_CLR;
      else if (!strobe_n && !step_n) op = OP_CNT_LOAD;
      else if (!strobe_n)           op = OP_CNT_RDBK;
      else if (!step_n)             op = OP_CNT_STEP;
      else                          op = OP_CNT_HOLD;
    end else begin
      if (!zero_n)                  op = OP_MSK_SET;
      else if (!strobe_n && !step_n) op = OP_MSK_LOAD;
      else if (!strobe_n)           op = OP_MSK_RDBK;
      else                          op = OP_RSVD;
    end
    return op;
  endfunction

endpackage

// File: rtl/bac_rst_sync.sv
module bac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bac_mask_reg.sv
module bac_mask_reg
  import bac_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bac_op_e           op,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] mask_q
);

  logic [ADDR_W-1:0] mask_d;
  logic              mask_en;

  always_comb begin
    mask_en = 1'b0;
    mask_d  = mask_q;
    unique case (op)
      OP_MSK_SET:  begin mask_en = 1'b1; mask_d = '1;      end
      OP_MSK_LOAD: begin mask_en = 1'b1; mask_d = addr_in; end
      default:     ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MSK_SET) |=> (&mask_q));

  assert_reserved_keeps_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RSVD) |=> $stable(mask_q));

endmodule

// File: rtl/bac_counter.sv
module bac_counter
  import bac_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bac_op_e           op,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] cnt_q,
  output logic              wrap
);

  logic [ADDR_W-1:0] mir_q;
  logic [ADDR_W-1:0] cnt_d, mir_d;
  logic              cnt_en, mir_en;
  logic [ADDR_W-1:0] step_unit;
  logic [ADDR_W-1:0] field_sum;
  logic              region_full;

  // lowest set bit of the mask is the step unit
  assign step_unit   = mask & (~mask + 1'b1);
  assign field_sum   = (cnt_q & mask) + step_unit;
  assign region_full = (mask != '0) && ((cnt_q & mask) == mask);
  assign wrap        = (op == OP_CNT_STEP) && region_full;

  always_comb begin
    cnt_en = 1'b0;
    mir_en = 1'b0;
    cnt_d  = cnt_q;
    mir_d  = mir_q;
    unique case (op)
      OP_CNT_CLR: begin
        cnt_en = 1'b1;
        mir_en = 1'b1;
        cnt_d  = cnt_q & ~mask;
        mir_d  = mir_q & ~mask;
      end
      OP_CNT_LOAD: begin
        cnt_en = 1'b1;
        mir_en = 1'b1;
        cnt_d  = addr_in;
        mir_d  = addr_in;
      end
      OP_CNT_STEP: begin
        cnt_en = 1'b1;
        cnt_d  = region_full ? mir_q : ((cnt_q & ~mask) | (field_sum & mask));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mir_q <= '0;
    else if (mir_en) mir_q <= mir_d;
  end

  assert_load_counter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CNT_LOAD) |=> (cnt_q == $past(addr_in)) && (mir_q == $past(addr_in)));

  assert_clear_keeps_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CNT_CLR) |=> ((cnt_q & $past(mask)) == '0) &&
                           ((cnt_q & ~$past(mask)) == ($past(cnt_q) & ~$past(mask))));

  assert_step_keeps_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CNT_STEP && !wrap) |=>
      ((cnt_q & ~$past(mask)) == ($past(cnt_q) & ~$past(mask))));

  assert_wrap_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == $past(mir_q)));

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CNT_HOLD) |=> $stable(cnt_q) && $stable(mir_q));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bac_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_counter,
  input  logic              zero_n,
  input  logic              strobe_n,
  input  logic              step_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] rdbk_data,
  output logic              rdbk_oe,
  output logic              wrap_irq
);

  logic              rst_sync_n;
  bac_op_e           op_raw;
  bac_op_e           op;
  logic [ADDR_W-1:0] mask_q;
  logic [ADDR_W-1:0] cnt_q;
  logic              wrap;

  bac_rst_sync #(.STAGES(RST_STAGE)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign op_raw = bac_decode(sel_counter, zero_n, strobe_n, step_n);
  // until reset has been released, every operation acts as a hold
  assign op     = rst_sync_n ? op_raw : OP_CNT_HOLD;

  bac_mask_reg #(.ADDR_W(ADDR_W)) i_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .addr_in (addr_in),
    .mask_q  (mask_q)
  );

  bac_counter #(.ADDR_W(ADDR_W)) i_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .addr_in (addr_in),
    .mask    (mask_q),
    .cnt_q   (cnt_q),
    .wrap    (wrap)
  );

  always_comb begin
    rdbk_oe   = 1'b0;
    rdbk_data = '0;
    if (op == OP_CNT_RDBK) begin
      rdbk_oe   = 1'b1;
      rdbk_data = cnt_q;
    end else if (op == OP_MSK_RDBK) begin
      rdbk_oe   = 1'b1;
      rdbk_data = mask_q;
    end
  end

  assign mem_addr = cnt_q;
  assign wrap_irq = wrap;

  assert_oe_only_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdbk_oe |-> (!strobe_n && step_n && zero_n));

  assert_irq_only_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_irq |-> (sel_counter && zero_n && strobe_n && !step_n));

  assert_mask_op_keeps_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !sel_counter) |=> $stable(mem_addr));

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sel_counter, zero_n, strobe_n, step_n;
  logic [W-1:0] addr_in;
  logic [W-1:0] mem_addr, rdbk_data;
  logic         rdbk_oe, wrap_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [W-1:0] m_cnt, m_mir, m_msk;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(W)) i_burst_addr_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_counter (sel_counter),
    .zero_n      (zero_n),
    .strobe_n    (strobe_n),
    .step_n      (step_n),
    .addr_in     (addr_in),
    .mem_addr    (mem_addr),
    .rdbk_data   (rdbk_data),
    .rdbk_oe     (rdbk_oe),
    .wrap_irq    (wrap_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit model_full();
    int ones = 0;
    if (m_msk == '0) return 0;
    for (int i = 0; i < W; i++)
      if (m_msk[i] && m_cnt[i]) ones++;
    return ones == $countones(m_msk);
  endfunction

  function automatic logic [W-1:0] model_step();
    int lsb = -1;
    logic [W-1:0] sum, res;
    for (int i = W - 1; i >= 0; i--) if (m_msk[i]) lsb = i;
    if (lsb < 0) return m_cnt;
    sum = m_cnt + (W'(1) << lsb);
    res = m_cnt;
    for (int i = 0; i < W; i++) if (m_msk[i]) res[i] = sum[i];
    return res;
  endfunction

  // one clock: inputs applied at negedge, outputs compared before and after the edge
  task automatic cyc(input logic s, input logic z, input logic sb, input logic e,
                     input logic [W-1:0] a);
    string tag;
    bit exp_oe, exp_irq;
    logic [W-1:0] exp_data;
    sel_counter = s; zero_n = z; strobe_n = sb; step_n = e; addr_in = a;
    #1;
    exp_oe   = z && !sb && e;
    exp_data = !exp_oe ? '0 : (s ? m_cnt : m_msk);
    exp_irq  = s && z && sb && !e && model_full();
    chk("R8", "rdbk_oe", W'(rdbk_oe), W'(exp_oe));
    chk(s ? "R8" : "R7", "rdbk_data", rdbk_data, exp_data);
    chk("R6", "wrap_irq", W'(wrap_irq), W'(exp_irq));
    if (s) begin
      if (!z) begin
        tag = "R4"; m_cnt = m_cnt & ~m_msk; m_mir = m_mir & ~m_msk;
      end else if (!sb && !e) begin
        tag = "R3"; m_cnt = a; m_mir = a;
      end else if (!sb) tag = "R8";
      else if (!e) begin
        if (model_full()) begin tag = "R6"; m_cnt = m_mir; end
        else begin tag = "R5"; m_cnt = model_step(); end
      end else tag = "R10";
    end else begin
      if (!z) begin tag = "R7"; m_msk = '1; end
      else if (!sb && !e) begin tag = "R7"; m_msk = a; end
      else if (!sb) tag = "R2";
      else tag = "R9";
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "mem_addr", mem_addr, m_cnt);
  endtask

  task automatic hold(); cyc(1, 1, 1, 1, '0); endtask
  task automatic load(input logic [W-1:0] a); cyc(1, 1, 0, 0, a); endtask
  task automatic step(); cyc(1, 1, 1, 0, '0); endtask
  task automatic clr(); cyc(1, 0, 1, 1, '0); endtask
  task automatic cnt_rb(); cyc(1, 1, 0, 1, '0); endtask
  task automatic msk_ld(input logic [W-1:0] a); cyc(0, 1, 0, 0, a); endtask
  task automatic msk_set(); cyc(0, 0, 1, 1, '0); endtask
  task automatic msk_rb(); cyc(0, 1, 0, 1, '0); endtask
  task automatic rsvd(input logic e); cyc(0, 1, 1, e, 16'hBEEF); endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sel_counter = 0; zero_n = 0; strobe_n = 0; step_n = 0; addr_in = 16'h1234;
    #3;
    chk("R1", "mem_addr in reset", mem_addr, '0);
    m_cnt = '0; m_mir = '0; m_msk = '1;
    @(negedge clk);
    rst_n = 1'b1;
    sel_counter = 1; zero_n = 1; strobe_n = 1; step_n = 1;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [W-1:0] rand_mask();
    int k = $urandom_range(0, W);
    logic [W-1:0] m = (k == W) ? '1 : ((W'(1) << k) - 1'b1);
    if ($urandom_range(0, 3) == 0) m[0] = 1'b0;
    return m;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: mask all ones after reset, counter zero
    msk_rb();
    // R1: mirror zero after reset, seen through a wrap on a 4-bit region
    msk_ld(16'h000F);
    for (int i = 0; i < 16; i++) step();
    chk("R1", "mirror zero via wrap", mem_addr, '0);

    // R3/R5: load, then step with a 3-bit region
    msk_ld(16'h0007);
    load(16'hA5F0);
    cnt_rb();
    for (int i = 0; i < 9; i++) step();   // crosses a wrap back to A5F0 (R6)

    // R5: bit 0 masked, steps of two
    msk_ld(16'h00FE);
    load(16'h33FA);
    for (int i = 0; i < 5; i++) step();

    // R4: clear keeps masked bits, also in mirror
    msk_ld(16'h00FF);
    load(16'h5A5A);
    clr();
    msk_ld(16'h000F);
    for (int i = 0; i < 16; i++) step();  // wrap shows mirror 5A00

    // R9/R10/R2: reserved, hold and mask readback leave state
    rsvd(0); rsvd(1); hold(); hold(); msk_rb();

    // R5: empty mask steps do nothing
    msk_ld(16'h0000);
    step(); step();
    msk_set(); msk_rb();

    // random mix with contiguous masks
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 15);
      logic [W-1:0] a = W'($urandom);
      case (r)
        0:       load(a);
        1:       clr();
        2:       cnt_rb();
        3:       hold();
        4:       msk_ld(rand_mask());
        5:       msk_set();
        6:       msk_rb();
        7:       rsvd(r[0]);
        default: step();
      endcase
    end

    // R1: reset in the middle of operation
    load(16'hFFFF);
    do_reset();
    msk_rb();
    step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule